// File: doc/BRIEF.md
# Dual-Clock Edge-Aligned FIR Tap Driver

This block feeds a flip-flop based analog FIR filter from a one-bit delta-sigma audio stream. The stream enters a shift register on the bit clock, and each stage of that register is one filter tap. Every tap drives an output register that is re-timed by two further clocks, a set clock and a clear clock, which run at the bit-clock rate with a phase offset between them. A tap output can go high only on a set-clock edge and go low only on a clear-clock edge. Moving the phase of one clock against the other lines up the rising and falling edges at the analog summing node.

Each tap has a true output and a complementary output for balanced drive. The complementary output comes from a second output stage of the same design that is fed the inverted tap bit. Before any output stage uses a tap bit, the bit is resynchronised into the set-clock domain and into the clear-clock domain through two flops each.

A parameter selects how the output register is built. In two-clock mode, each output is a pair of toggle flops, one per clock domain, and their XOR forms the output. This acts like a single register that has two clocks with data-selected enables. In the other mode the register is clocked only by the set clock and is cleared asynchronously from the clear-clock domain. That mode suits fabrics that cannot give one register two clocks.

Top module: `edge_fir_taps`

## Requirements
- R1: The shift line is clocked by `bclk_i`. Tap 0 holds the newest bit, and in steady operation `tap_o[k]` follows the same sequence as `tap_o[0]` delayed by k bit-clock periods.
- R2: Outside reset, a 0-to-1 transition on any bit of `tap_o` or `tap_n_o` happens only at a rising edge of `set_clk_i`.
- R3: Outside reset, a 1-to-0 transition on any bit of `tap_o` or `tap_n_o` happens only at a rising edge of `clr_clk_i`.
- R4: In two-clock mode (`MODE` = 0), a bit captured into tap 0 at a `bclk_i` edge drives `tap_o[0]` high at the third following `set_clk_i` edge if it is 1. If it is 0, it drives `tap_o[0]` low at the third following `clr_clk_i` edge.
- R5: Outside reset and once transitions have settled, `tap_n_o[k]` is the inverse of `tap_o[k]` for every k.
- R6: While `rst_ni` is low, every bit of `tap_o` is 0 and every bit of `tap_n_o` is 1. These values appear without waiting for a clock edge and stay there whatever `bit_i` does. Reset also clears the tap history, so after reset is released every bit captured earlier reads as 0.
- R7: In synchronous-set/asynchronous-clear mode (`MODE` = 1), a captured 1 drives `tap_o[0]` high at the third following `set_clk_i` edge. A captured 0 drives it low at the second following `clr_clk_i` edge. R1, R2, R3, R5 and R6 hold in this mode as well.
- R8: While a tap's bit stays 1, clear-clock edges leave its true output at 1. While the bit stays 0, set-clock edges leave the true output at 0. A long run of equal bits therefore produces no output transitions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk_i | input | 1 | Bit clock of the delta-sigma stream; clocks the shift line |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Delta-sigma data bit, sampled on rising `bclk_i` |
| set_clk_i | input | 1 | Phase-shifted clock that produces rising output edges |
| clr_clk_i | input | 1 | Phase-shifted clock that produces falling output edges |
| tap_o | output | TAPS | True tap outputs, bit k is tap k |
| tap_n_o | output | TAPS | Complementary tap outputs |

## Verification
The checker runs on every cycle and watches the edge rule from both sides. It compares the outputs just before each set-clock edge with their values before the previous clear-clock edge, so no rise can come from a clear edge (R2). It makes the mirror comparison for falls at set edges (R3). It also checks that each tap repeats its neighbour one bit period later (R1) and that the two output polarities agree at settled sample points (R5). The exact latency in each mode (R4, R7), reset during a stream with history clearing (R6), and steady outputs through long runs (R8) need a known input stream. Only the bench scenarios can show these, by comparing outputs with a delayed copy of the bits they drive.

// File: rtl/fir_tap_pkg.sv
`timescale 1ns/1ps
package fir_tap_pkg;
  typedef enum logic {
    MODE_TWO_CLK   = 1'b0,
    MODE_ASYNC_CLR = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/tap_shift_line.sv
`timescale 1ns/1ps
module tap_shift_line #(
  parameter int unsigned TAPS = 4
) (
  input  logic            bclk_i,
  input  logic            rst_ni,
  input  logic            bit_i,
  output logic [TAPS-1:0] taps_o
);
  logic [TAPS-1:0] line_q;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= {line_q[TAPS-2:0], bit_i};
  end

  assign taps_o = line_q;
endmodule

// File: rtl/tap_sync.sv
`timescale 1ns/1ps
module tap_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tap_out_stage.sv
`timescale 1ns/1ps
module tap_out_stage
  import fir_tap_pkg::*;
#(
  parameter clr_mode_e MODE = MODE_TWO_CLK,
  parameter logic      INIT = 1'b0
) (
  input  logic set_clk_i,
  input  logic clr_clk_i,
  input  logic rst_ni,
  input  logic d_set_i,
  input  logic d_clr_i,
  output logic q_o
);
  if (MODE == MODE_TWO_CLK) begin : g_two_clk
    // one toggle flop per domain; XOR acts as a register with two gated clocks
    logic tog_set_q, tog_clr_q;

    always_ff @(posedge set_clk_i or negedge rst_ni) begin
      if (!rst_ni)                tog_set_q <= INIT;
      else if (d_set_i && !q_o)   tog_set_q <= ~tog_set_q;
    end

    always_ff @(posedge clr_clk_i or negedge rst_ni) begin
      if (!rst_ni)                tog_clr_q <= 1'b0;
      else if (!d_clr_i && q_o)   tog_clr_q <= ~tog_clr_q;
    end

    assign q_o = tog_set_q ^ tog_clr_q;
  end else begin : g_async_clr
    logic clr_req;
    logic out_q;

    assign clr_req = ~d_clr_i;  // driven by a single clear-domain flop, glitch free

    always_ff @(posedge set_clk_i or posedge clr_req or negedge rst_ni) begin
      if (!rst_ni)      out_q <= INIT;
      else if (clr_req) out_q <= 1'b0;
      else if (d_set_i) out_q <= 1'b1;
    end

    assign q_o = out_q;
  end
endmodule

// File: rtl/edge_fir_taps.sv
`timescale 1ns/1ps
module edge_fir_taps
  import fir_tap_pkg::*;
#(
  parameter int unsigned TAPS        = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter clr_mode_e   MODE        = MODE_TWO_CLK
) (
  input  logic            bclk_i,
  input  logic            rst_ni,
  input  logic            bit_i,
  input  logic            set_clk_i,
  input  logic            clr_clk_i,
  output logic [TAPS-1:0] tap_o,
  output logic [TAPS-1:0] tap_n_o
);
  logic [TAPS-1:0] taps;
  logic [TAPS-1:0] taps_set;
  logic [TAPS-1:0] taps_clr;

  tap_shift_line #(.TAPS(TAPS)) line_i (
    .bclk_i (bclk_i),
    .rst_ni (rst_ni),
    .bit_i  (bit_i),
    .taps_o (taps)
  );

  tap_sync #(.W(TAPS), .STAGES(SYNC_STAGES)) sync_set_i (
    .clk_i  (set_clk_i),
    .rst_ni (rst_ni),
    .d_i    (taps),
    .q_o    (taps_set)
  );

  tap_sync #(.W(TAPS), .STAGES(SYNC_STAGES)) sync_clr_i (
    .clk_i  (clr_clk_i),
    .rst_ni (rst_ni),
    .d_i    (taps),
    .q_o    (taps_clr)
  );

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    tap_out_stage #(.MODE(MODE), .INIT(1'b0)) pos_i (
      .set_clk_i (set_clk_i),
      .clr_clk_i (clr_clk_i),
      .rst_ni    (rst_ni),
      .d_set_i   (taps_set[k]),
      .d_clr_i   (taps_clr[k]),
      .q_o       (tap_o[k])
    );

    tap_out_stage #(.MODE(MODE), .INIT(1'b1)) neg_i (
      .set_clk_i (set_clk_i),
      .clr_clk_i (clr_clk_i),
      .rst_ni    (rst_ni),
      .d_set_i   (~taps_set[k]),
      .d_clr_i   (~taps_clr[k]),
      .q_o       (tap_n_o[k])
    );
  end
endmodule

// File: rtl/edge_fir_taps_chk.sv
`timescale 1ns/1ps
// Edge rules assume set, clear and bit clocks share one frequency.
module edge_fir_taps_chk
  import fir_tap_pkg::*;
#(
  parameter int unsigned TAPS = 4,
  parameter clr_mode_e   MODE = MODE_TWO_CLK
) (
  input logic            bclk_i,
  input logic            rst_ni,
  input logic            set_clk_i,
  input logic            clr_clk_i,
  input logic [TAPS-1:0] tap_o,
  input logic [TAPS-1:0] tap_n_o
);
  localparam logic [2*TAPS-1:0] RST_VAL = {{TAPS{1'b1}}, {TAPS{1'b0}}};

  logic [2*TAPS-1:0] cur;
  logic [2*TAPS-1:0] pre_set_q, pre_clr_q;
  logic              armed_q;

  assign cur = {tap_n_o, tap_o};

  always_ff @(posedge set_clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_set_q <= RST_VAL;
    else         pre_set_q <= cur;
  end

  always_ff @(posedge clr_clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_clr_q <= RST_VAL;
    else         pre_clr_q <= cur;
  end

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R2: nothing rose across the last clear edge
  a_r2_rise_on_set: assert property (@(posedge set_clk_i) disable iff (!rst_ni)
    ((~pre_clr_q & cur) == '0));

  // R3: nothing fell across the last set edge
  a_r3_fall_on_clr: assert property (@(posedge clr_clk_i) disable iff (!rst_ni)
    ((pre_set_q & ~cur) == '0));

  for (genvar k = 1; k < TAPS; k++) begin : g_step
    a_r1_tap_step: assert property (@(posedge bclk_i) disable iff (!rst_ni)
      armed_q |-> (tap_o[k] == $past(tap_o[k-1])));
  end

  if (MODE == MODE_TWO_CLK) begin : g_cmp_two
    a_r5_complement: assert property (@(posedge bclk_i) disable iff (!rst_ni)
      (tap_n_o == ~tap_o));
  end else begin : g_cmp_async
    a_r5_complement: assert property (@(posedge clr_clk_i) disable iff (!rst_ni)
      (tap_n_o == ~tap_o));
  end
endmodule

bind edge_fir_taps edge_fir_taps_chk #(.TAPS(TAPS), .MODE(MODE)) chk_i (
  .bclk_i    (bclk_i),
  .rst_ni    (rst_ni),
  .set_clk_i (set_clk_i),
  .clr_clk_i (clr_clk_i),
  .tap_o     (tap_o),
  .tap_n_o   (tap_n_o)
);

// File: tb/edge_fir_taps_tb_top.sv
`timescale 1ns/1ps
module edge_fir_taps_tb_top;
  import fir_tap_pkg::*;

  localparam int unsigned TAPS   = 4;
  localparam int          NPAT   = 5;
  localparam int          NBITS  = NPAT * 32;
  localparam int          HIST   = 512;
  // stimulus words, walked LSB first; expected outputs are computed from them
  localparam logic [31:0] PATS [NPAT] = '{
    32'h0000_0001,   // single impulse
    32'hFFFF_0000,   // long zero run then long one run
    32'hAAAA_AAAA,   // maximum toggle rate
    32'h0F0F_3C69,   // mixed
    32'hFFFF_FFFF    // sustained ones (R8)
  };

  logic bclk, set_clk, clr_clk, rst_ni, bit_i;
  logic [TAPS-1:0] t0, t0n, t1, t1n;
  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic hist [HIST];

  // bclk rises at 10+20n, set clock at 15+20n, clear clock at 22+20n
  initial begin bclk = 0;    #10; forever begin bclk = 1;    #10; bclk = 0;    #10; end end
  initial begin set_clk = 0; #15; forever begin set_clk = 1; #10; set_clk = 0; #10; end end
  initial begin clr_clk = 0; #22; forever begin clr_clk = 1; #10; clr_clk = 0; #10; end end

  edge_fir_taps #(.TAPS(TAPS), .MODE(MODE_TWO_CLK)) dut_i (
    .bclk_i(bclk), .rst_ni(rst_ni), .bit_i(bit_i),
    .set_clk_i(set_clk), .clr_clk_i(clr_clk), .tap_o(t0), .tap_n_o(t0n));

  edge_fir_taps #(.TAPS(TAPS), .MODE(MODE_ASYNC_CLR)) dut_ac_i (
    .bclk_i(bclk), .rst_ni(rst_ni), .bit_i(bit_i),
    .set_clk_i(set_clk), .clr_clk_i(clr_clk), .tap_o(t1), .tap_n_o(t1n));

  task automatic chk(input string tag, input logic [TAPS-1:0] act, input logic [TAPS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edge_chk(input string who, input logic [2*TAPS-1:0] prv, input logic [2*TAPS-1:0] cur);
    for (int k = 0; k < 2*TAPS; k++) begin
      if (cur[k] === 1'b1 && prv[k] === 1'b0) begin
        checks++;
        if (($time % 20) != 15) begin
          errors++;
          $display("FAIL R2 %s bit %0d rose at phase %0d exp 15", who, k, $time % 20);
        end
      end else if (cur[k] === 1'b0 && prv[k] === 1'b1) begin
        checks++;
        if (($time % 20) != 2) begin
          errors++;
          $display("FAIL R3 %s bit %0d fell at phase %0d exp 2", who, k, $time % 20);
        end
      end
    end
  endtask

  logic [2*TAPS-1:0] prev0, prev1;
  always @(t0 or t0n) begin
    if (rst_ni === 1'b1 && !done) edge_chk("mode0", prev0, {t0n, t0});
    prev0 = {t0n, t0};
  end
  always @(t1 or t1n) begin
    if (rst_ni === 1'b1 && !done) edge_chk("mode1", prev1, {t1n, t1});
    prev1 = {t1n, t1};
  end

  function automatic logic src_bit(input int n, input int kind);
    if (kind == 0 && n < NBITS) return PATS[n/32][n%32];
    return 1'b0;
  endfunction

  // tap k at sample n shows the bit captured at edge n-2-k (R4, R7 latencies)
  function automatic logic [TAPS-1:0] exp_at(input int n);
    logic [TAPS-1:0] v;
    for (int k = 0; k < TAPS; k++) v[k] = (n - 2 - k >= 0) ? hist[n-2-k] : 1'b0;
    return v;
  endfunction

  // caller stands at a falling bclk edge with reset released
  task automatic run_stream(input int len, input int kind);
    logic b;
    logic [TAPS-1:0] e;
    string tag0, tag1;
    for (int i = 0; i < HIST; i++) hist[i] = 1'b0;
    b = src_bit(0, kind); hist[0] = b; bit_i = b;
    for (int n = 0; n < len; n++) begin
      @(posedge bclk);
      e = exp_at(n);
      if (kind == 0 && n >= 4*32 + 2 + TAPS) begin tag0 = "R8 mode0"; tag1 = "R8 mode1"; end
      else if (kind == 1) begin tag0 = "R6 history mode0"; tag1 = "R6 history mode1"; end
      else begin tag0 = "R1 R4 mode0"; tag1 = "R1 R7 mode1"; end
      #8;
      chk(tag1, t1, e);
      chk({"R5 ", tag1}, t1n, ~e);
      #2;
      if (n + 1 < len) begin b = src_bit(n+1, kind); hist[n+1] = b; bit_i = b; end
      #8;
      chk(tag0, t0, e);
      chk({"R5 ", tag0}, t0n, ~e);
    end
  endtask

  initial begin
    rst_ni = 1'b0;
    bit_i  = 1'b1;  // must be ignored in reset (R6)
    repeat (5) @(posedge bclk);
    #8;
    chk("R6 reset mode0 tap_o", t0, '0);
    chk("R6 reset mode0 tap_n_o", t0n, '1);
    chk("R6 reset mode1 tap_o", t1, '0);
    chk("R6 reset mode1 tap_n_o", t1n, '1);
    @(negedge bclk);
    rst_ni = 1'b1;
    run_stream(NBITS, 0);
    // all taps high after the sustained-ones word
    chk("R8 end of ones mode0", t0, '1);
    chk("R8 end of ones mode1", t1, '1);
    // asynchronous reset in mid cycle with outputs high
    #5;
    rst_ni = 1'b0;
    #1;
    chk("R6 async mode0 tap_o", t0, '0);
    chk("R6 async mode0 tap_n_o", t0n, '1);
    chk("R6 async mode1 tap_o", t1, '0);
    chk("R6 async mode1 tap_n_o", t1n, '1);
    repeat (4) @(posedge bclk);
    #8;
    chk("R6 hold mode0", t0, '0);
    chk("R6 hold mode1", t1n, '1);
    @(negedge bclk);
    rst_ni = 1'b1;
    run_stream(12, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5000 * 20);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule